// File: doc/BRIEF.md
# DMA Bus Ownership Sequencer

This block decides when one DMA channel takes a shared system bus and when it hands the bus back. It works in dual-address fashion: every transfer unit is a read bus cycle followed by a write bus cycle. The block raises a bus request, waits for the grant and then strobes the read and write cycles. It counts the units down from a loaded value and pulses a completion flag after the final write.

Two ownership policies exist. With interleaved (cycle-steal) ownership, the bus is handed back after every unit. With continuous (burst) ownership, units follow each other with no gap until the count runs out. A continuous run that follows a low-active external request line is cut short when that line goes high. The unit already under way finishes first, the bus is then released, and the run resumes when the line drops again. The serial-port and converter request sources cannot hold the bus continuously, so they always fall back to interleaving. They also cannot use the 128-bit size, which is narrowed to 32 bits for them. A 128-bit unit is carried out as four 32-bit read/write pairs. Only channels whose index is below a parameter limit may follow the external request line and drive the acknowledge.

Top module: `dma_busmode_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, bus_req, rd_cyc, wr_cyc, dack and done are all low.
- R2: Each transfer pair is one rd_cyc cycle followed directly by one wr_cyc cycle. rd_cyc and wr_cyc are never high together. rd_cyc is high only while bus_req is high.
- R3: With burst_sel=1 and a source of 0 (always requesting) or 1 (external line held low), no cycle with bus_req low appears between the first read and done.
- R4: With burst_sel=0, exactly one cycle with bus_req low separates consecutive units, which gives count-1 such cycles per job.
- R5: Sources 2 (serial) and 3 (converter) behave as in R4 even when burst_sel=1.
- R6: In a burst on source 1, when dreq_n goes high during a read, the matching write still occurs and bus_req is low in the next cycle. bus_req stays low, with no further reads, while dreq_n stays high.
- R7: When dreq_n returns low after such a release, bus_req is high again one cycle later, and the job completes its full remaining count.
- R8: size_sel encodes 0=8, 1=16, 2=32 and 3=128 bits. A 128-bit unit gives four read/write pairs and lowers the count by one. The other sizes give one pair per unit. beat_size reports the effective code while reads run.
- R9: size_sel=3 with source 2 or 3 is carried out as 32-bit units (beat_size=2, one pair per unit).
- R10: done is high for exactly one cycle, the cycle after the last write. A start with xfer_cnt=0 produces no bus request and no done.
- R11: dack is high exactly in the rd_cyc and wr_cyc cycles of a job whose source is 1, and is low for all other sources.
- R12: On a channel whose CHAN_ID is not below EXT_CHANS, source 1 never raises bus_req or dack.
- R13: Source, mode, size and count are captured when start is seen in idle. A start or configuration change while a job runs has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job (taken only when idle) |
| req_src | input | 2 | Request source: 0 auto, 1 external line, 2 serial, 3 converter |
| burst_sel | input | 1 | 1 asks for continuous ownership |
| size_sel | input | 2 | Unit size code (R8) |
| xfer_cnt | input | CNT_W | Number of units |
| dreq_n | input | 1 | External request line, active low, level sensed |
| periph_req | input | 1 | On-chip peripheral request, active high |
| bus_grant | input | 1 | Bus granted to this channel |
| bus_req | output | 1 | Bus request |
| rd_cyc | output | 1 | Read bus cycle strobe |
| wr_cyc | output | 1 | Write bus cycle strobe |
| dack | output | 1 | External acknowledge |
| done | output | 1 | One-cycle completion pulse |
| beat_size | output | 2 | Effective size code |

## Verification
Each job of a full sweep over source, ownership mode, size code and a count of one or three has its reads, writes, released cycles, acknowledge cycles and completion pulses counted. A count of one against three separates the per-unit bus release from a release at the end of a job. The burst request on sources 2 and 3 shows whether the fallback to interleaving and the narrowing of the 128-bit size happen. Separate runs raise dreq_n partway through a burst, restart while busy, start with a zero count, and drive a second channel above the acknowledge limit. These show the early release and resume, that configuration is captured at start, and that the external source is blocked on that channel.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    SRC_AUTO   = 2'd0,
    SRC_EXT    = 2'd1,
    SRC_SERIAL = 2'd2,
    SRC_ADC    = 2'd3
  } req_src_e;

  typedef enum logic [1:0] {
    SZ_8   = 2'd0,
    SZ_16  = 2'd1,
    SZ_32  = 2'd2,
    SZ_128 = 2'd3
  } xfer_size_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ARM  = 3'd1,
    ST_REQ  = 3'd2,
    ST_RD   = 3'd3,
    ST_WR   = 3'd4
  } bus_state_e;

  typedef struct packed {
    req_src_e   src;
    logic       burst;
    xfer_size_e size;
  } chan_cfg_t;
endpackage

// File: rtl/dma_req_sel.sv
module dma_req_sel
  import dma_seq_pkg::*;
#(
  parameter int CHAN_ID   = 0,
  parameter int EXT_CHANS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [1:0] src_in,
  input  logic       burst_in,
  input  logic [1:0] size_in,
  input  logic       dreq_n,
  input  logic       periph_req,
  output logic       req_active,
  output logic       burst_eff,
  output logic       ext_mode,
  output logic       wide_unit,
  output logic [1:0] size_eff
);
  localparam bit EXT_OK = (CHAN_ID < EXT_CHANS);

  chan_cfg_t cfg_q;
  logic      periph_src;
  logic      ext_req;
  logic      ext_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (load) begin
      cfg_q.src   <= req_src_e'(src_in);
      cfg_q.burst <= burst_in;
      cfg_q.size  <= xfer_size_e'(size_in);
    end
  end

  assign periph_src = (cfg_q.src == SRC_SERIAL) || (cfg_q.src == SRC_ADC);

  generate
    if (EXT_OK) begin : g_ext
      assign ext_req = !dreq_n;
      assign ext_sel = (cfg_q.src == SRC_EXT);
    end else begin : g_noext
      assign ext_req = dreq_n & 1'b0;
      assign ext_sel = 1'b0;
    end
  endgenerate

  always_comb begin
    case (cfg_q.src)
      SRC_AUTO: req_active = 1'b1;
      SRC_EXT:  req_active = ext_req;
      default:  req_active = periph_req;
    endcase
  end

  assign burst_eff = cfg_q.burst && !periph_src;
  assign size_eff  = (cfg_q.size == SZ_128 && periph_src) ? SZ_32 : cfg_q.size;
  assign wide_unit = (size_eff == SZ_128);
  assign ext_mode  = ext_sel;
endmodule

// File: rtl/dma_unit_ctr.sv
module dma_unit_ctr #(
  parameter int CNT_W = 8,
  parameter int BEATS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             wide_unit,
  input  logic             beat_done,
  output logic             unit_last,
  output logic             cnt_last
);
  localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [BW-1:0]    beat_q;
  logic [CNT_W-1:0] remain_q;

  assign unit_last = !wide_unit || (beat_q == BW'(BEATS - 1));
  assign cnt_last  = (remain_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q   <= '0;
      remain_q <= '0;
    end else if (load) begin
      beat_q   <= '0;
      remain_q <= load_cnt;
    end else if (beat_done) begin
      if (unit_last) begin
        beat_q   <= '0;
        remain_q <= remain_q - CNT_W'(1);
      end else begin
        beat_q <= beat_q + BW'(1);
      end
    end
  end

  // R8
  unit_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_done && unit_last && !load) |=> (remain_q == $past(remain_q) - CNT_W'(1)));

  // R8
  beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_done && !unit_last && !load) |=> (remain_q == $past(remain_q)));
endmodule

// File: rtl/dma_bus_fsm.sv
module dma_bus_fsm
  import dma_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic req_active,
  input  logic bus_grant,
  input  logic burst_eff,
  input  logic ext_mode,
  input  logic unit_last,
  input  logic cnt_last,
  output logic idle,
  output logic beat_done,
  output logic bus_req_o,
  output logic rd_o,
  output logic wr_o,
  output logic dack_o,
  output logic done_o
);
  bus_state_e state_q, state_d;
  logic       job_end;
  logic       unit_end;

  assign unit_end  = (state_q == ST_WR) && unit_last;
  assign job_end   = unit_end && cnt_last;
  assign idle      = (state_q == ST_IDLE);
  assign beat_done = (state_q == ST_WR);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_ARM;
      ST_ARM:  if (req_active) state_d = ST_REQ;
      ST_REQ:  if (bus_grant) state_d = ST_RD;
      ST_RD:   state_d = ST_WR;
      ST_WR: begin
        if (!unit_last)                    state_d = ST_RD;
        else if (cnt_last)                 state_d = ST_IDLE;
        else if (burst_eff && req_active)  state_d = ST_RD;
        else                               state_d = ST_ARM;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      bus_req_o <= 1'b0;
      rd_o      <= 1'b0;
      wr_o      <= 1'b0;
      dack_o    <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      state_q   <= state_d;
      bus_req_o <= (state_d == ST_REQ) || (state_d == ST_RD) || (state_d == ST_WR);
      rd_o      <= (state_d == ST_RD);
      wr_o      <= (state_d == ST_WR);
      dack_o    <= ext_mode && ((state_d == ST_RD) || (state_d == ST_WR));
      done_o    <= job_end;
    end
  end

  // R2
  rw_excl_chk: assert property (@(posedge clk) disable iff (rst) !(rd_o && wr_o));

  // R2
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst) wr_o |-> $past(rd_o));

  // R2
  rd_owned_chk: assert property (@(posedge clk) disable iff (rst) rd_o |-> bus_req_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o);

  // R10
  done_after_wr_chk: assert property (@(posedge clk) disable iff (rst) done_o |-> $past(wr_o));

  // R4
  steal_release_chk: assert property (@(posedge clk) disable iff (rst)
    (unit_end && !cnt_last && !burst_eff) |=> !bus_req_o);

  // R3
  burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (unit_end && !cnt_last && burst_eff && req_active) |=> (rd_o && bus_req_o));

  // R6
  early_release_chk: assert property (@(posedge clk) disable iff (rst)
    (unit_end && !cnt_last && !req_active) |=> !bus_req_o);

  // R11
  dack_window_chk: assert property (@(posedge clk) disable iff (rst)
    dack_o |-> (rd_o || wr_o));
endmodule

// File: rtl/dma_busmode_seq.sv
module dma_busmode_seq
  import dma_seq_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int CHAN_ID   = 0,
  parameter int EXT_CHANS = 2,
  parameter int BUS_W     = 32,
  parameter int WIDE_W    = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       req_src,
  input  logic             burst_sel,
  input  logic [1:0]       size_sel,
  input  logic [CNT_W-1:0] xfer_cnt,
  input  logic             dreq_n,
  input  logic             periph_req,
  input  logic             bus_grant,
  output logic             bus_req,
  output logic             rd_cyc,
  output logic             wr_cyc,
  output logic             dack,
  output logic             done,
  output logic [1:0]       beat_size
);
  localparam int BEATS = WIDE_W / BUS_W;

  logic       idle, load, beat_done;
  logic       req_active, burst_eff, ext_mode, wide_unit;
  logic       unit_last, cnt_last;
  logic [1:0] size_eff;

  assign load = start && idle;

  dma_req_sel #(.CHAN_ID(CHAN_ID), .EXT_CHANS(EXT_CHANS)) u_sel (
    .clk(clk), .rst(rst), .load(load),
    .src_in(req_src), .burst_in(burst_sel), .size_in(size_sel),
    .dreq_n(dreq_n), .periph_req(periph_req),
    .req_active(req_active), .burst_eff(burst_eff), .ext_mode(ext_mode),
    .wide_unit(wide_unit), .size_eff(size_eff)
  );

  dma_unit_ctr #(.CNT_W(CNT_W), .BEATS(BEATS)) u_ctr (
    .clk(clk), .rst(rst), .load(load), .load_cnt(xfer_cnt),
    .wide_unit(wide_unit), .beat_done(beat_done),
    .unit_last(unit_last), .cnt_last(cnt_last)
  );

  dma_bus_fsm u_fsm (
    .clk(clk), .rst(rst), .start(load && (xfer_cnt != '0)),
    .req_active(req_active), .bus_grant(bus_grant), .burst_eff(burst_eff),
    .ext_mode(ext_mode), .unit_last(unit_last), .cnt_last(cnt_last),
    .idle(idle), .beat_done(beat_done),
    .bus_req_o(bus_req), .rd_o(rd_cyc), .wr_o(wr_cyc),
    .dack_o(dack), .done_o(done)
  );

  always_ff @(posedge clk) begin
    if (rst) beat_size <= 2'd0;
    else     beat_size <= size_eff;
  end
endmodule

// File: tb/dma_busmode_seq_tb.sv
module dma_busmode_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0, start2 = 1'b0;
  logic [1:0] req_src = 2'd0, size_sel = 2'd0;
  logic       burst_sel = 1'b0;
  logic [7:0] xfer_cnt = 8'd0;
  logic       dreq_n = 1'b1, periph_req = 1'b1;
  logic       bus_req, rd_cyc, wr_cyc, dack, done;
  logic [1:0] beat_size;
  logic       bus_req2, rd2, wr2, dack2, done2;
  logic [1:0] bsz2;

  always #2.5 clk = ~clk;

  dma_busmode_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .req_src(req_src), .burst_sel(burst_sel),
    .size_sel(size_sel), .xfer_cnt(xfer_cnt), .dreq_n(dreq_n), .periph_req(periph_req),
    .bus_grant(bus_req), .bus_req(bus_req), .rd_cyc(rd_cyc), .wr_cyc(wr_cyc),
    .dack(dack), .done(done), .beat_size(beat_size)
  );

  dma_busmode_seq #(.CHAN_ID(2)) dut2_i (
    .clk(clk), .rst(rst), .start(start2), .req_src(req_src), .burst_sel(burst_sel),
    .size_sel(size_sel), .xfer_cnt(xfer_cnt), .dreq_n(dreq_n), .periph_req(periph_req),
    .bus_grant(bus_req2), .bus_req(bus_req2), .rd_cyc(rd2), .wr_cyc(wr2),
    .dack(dack2), .done(done2), .beat_size(bsz2)
  );

  int n_chk = 0, n_fail = 0;
  int job_id = 0, seen_id = 0, cur_src = 0;
  int rd_n, wr_n, gap_n, run_n, max_run, done_n, dack_err, seq_err, req_n;
  bit started, finished, prev_rd, prev_wr;
  logic [1:0] last_size;

  always @(negedge clk) begin
    if (seen_id != job_id) begin
      rd_n = 0; wr_n = 0; gap_n = 0; run_n = 0; max_run = 0; done_n = 0;
      dack_err = 0; seq_err = 0; req_n = 0; started = 0; finished = 0;
      last_size = 2'd0; seen_id = job_id;
    end
    if (rd_cyc) begin rd_n++; last_size = beat_size; started = 1; end
    if (wr_cyc) begin wr_n++; if (!prev_rd) seq_err++; end
    if (rd_cyc && wr_cyc) seq_err++;
    if (bus_req) req_n++;
    if (dack !== ((cur_src == 1) && (rd_cyc || wr_cyc))) dack_err++;
    if (done) begin
      done_n++; if (!prev_wr) seq_err++; finished = 1;
    end else if (started && !finished) begin
      if (!bus_req) begin gap_n++; run_n++; if (run_n > max_run) max_run = run_n; end
      else run_n = 0;
    end
    prev_rd = rd_cyc; prev_wr = wr_cyc;
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic launch(int src, int burst, int size, int cnt);
    tick();
    job_id++; cur_src = src;
    req_src = 2'(src); burst_sel = 1'(burst); size_sel = 2'(size);
    xfer_cnt = 8'(cnt); start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic wait_done(int lim);
    for (int i = 0; i < lim && done_n == 0; i++) tick();
    tick();
    chk(done_n != 0, "R10 completion seen", done_n, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog: actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) tick();
    chk({bus_req, rd_cyc, wr_cyc, dack, done} == 5'b0, "R1 in reset",
        int'({bus_req, rd_cyc, wr_cyc, dack, done}), 0);
    rst = 1'b0;
    tick();
    chk({bus_req, rd_cyc, wr_cyc, dack, done, bus_req2} == 6'b0, "R1 after reset",
        int'({bus_req, rd_cyc, wr_cyc, dack, done, bus_req2}), 0);

    // Sweep: R2 R3 R4 R5 R8 R9 R10 R11
    dreq_n = 1'b0;
    for (int src = 0; src < 4; src++)
      for (int burst = 0; burst < 2; burst++)
        for (int size = 0; size < 4; size++)
          for (int ci = 0; ci < 2; ci++) begin
            int cnt, esz, pairs, egap, erun;
            bit beff;
            cnt   = (ci == 0) ? 1 : 3;
            esz   = (size == 3 && src >= 2) ? 2 : size;
            pairs = cnt * ((esz == 3) ? 4 : 1);
            beff  = (burst == 1) && (src < 2);
            egap  = beff ? 0 : cnt - 1;
            erun  = (!beff && cnt > 1) ? 1 : 0;
            launch(src, burst, size, cnt);
            wait_done(400);
            chk(rd_n == pairs, "R8 read count", rd_n, pairs);
            chk(wr_n == pairs, "R2 write count", wr_n, pairs);
            chk(seq_err == 0, "R2 ordering", seq_err, 0);
            if (beff)            chk(gap_n == egap, "R3 burst gaps", gap_n, egap);
            else if (src >= 2 && burst == 1) chk(gap_n == egap, "R5 forced steal gaps", gap_n, egap);
            else                 chk(gap_n == egap, "R4 steal gaps", gap_n, egap);
            chk(max_run == erun, "R4 release run", max_run, erun);
            chk(done_n == 1, "R10 done pulses", done_n, 1);
            chk(dack_err == 0, "R11 acknowledge", dack_err, 0);
            if (size == 3 && src >= 2) chk(last_size == 2'(esz), "R9 narrowed size", int'(last_size), esz);
            else                       chk(last_size == 2'(esz), "R8 size code", int'(last_size), esz);
          end

    // R6 / R7: early release and resume
    begin
      int nrd;
      bit held;
      dreq_n = 1'b0;
      launch(1, 1, 2, 6);
      nrd = 0;
      for (int i = 0; i < 50 && nrd < 2; i++) begin
        tick();
        if (rd_cyc) nrd++;
      end
      dreq_n = 1'b1;
      tick();
      chk(wr_cyc == 1'b1, "R6 accepted unit completes", int'(wr_cyc), 1);
      tick();
      chk(bus_req == 1'b0, "R6 bus released", int'(bus_req), 0);
      held = 1;
      for (int i = 0; i < 5; i++) begin
        tick();
        if (bus_req || rd_cyc) held = 0;
      end
      chk(held && rd_n == 2, "R6 release held", rd_n, 2);
      dreq_n = 1'b0;
      tick();
      chk(bus_req == 1'b1, "R7 request again", int'(bus_req), 1);
      wait_done(200);
      chk(rd_n == 6, "R7 full count", rd_n, 6);
      chk(done_n == 1, "R7 single done", done_n, 1);
    end

    // R13: restart while busy ignored
    launch(0, 1, 2, 3);
    req_src = 2'd2; burst_sel = 1'b0; size_sel = 2'd3; xfer_cnt = 8'd9; start = 1'b1;
    tick();
    start = 1'b0;
    wait_done(200);
    chk(rd_n == 3, "R13 count kept", rd_n, 3);
    chk(gap_n == 0, "R13 mode kept", gap_n, 0);
    chk(last_size == 2'd2, "R13 size kept", int'(last_size), 2);

    // R10: zero count
    launch(0, 1, 2, 0);
    repeat (10) tick();
    chk(req_n == 0 && done_n == 0, "R10 zero count", req_n + done_n, 0);

    // R12: channel above limit ignores external source
    begin
      bit quiet;
      dreq_n = 1'b0; req_src = 2'd1; burst_sel = 1'b1; size_sel = 2'd2; xfer_cnt = 8'd2;
      tick();
      start2 = 1'b1;
      tick();
      start2 = 1'b0;
      quiet = 1;
      for (int i = 0; i < 20; i++) begin
        tick();
        if (bus_req2 || dack2 || done2) quiet = 0;
      end
      chk(quiet, "R12 blocked channel", int'(quiet), 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule